// File: doc/BRIEF.md
# SPI Target Core with Stall Timeout

This block is the target (peripheral) end of a four-wire SPI link. It brings the external serial clock, select and data-in lines into the system clock domain through synchroniser chains and finds the serial clock edges on the synchronised copy. One frame carries one word, most significant bit first. When the select line goes active, the core asks a local transmit FIFO for the word to send back. It shifts that word out on MISO while it shifts the incoming bits into a receive register. When select is released after a full word, the received word is presented with a one-cycle valid strobe.

Clock polarity and phase are programmable. A mode written while a frame is running is held and only applied once the frame has ended. A frame whose serial clock stops for too long is aborted. The partial word is dropped and a one-cycle interrupt pulse is raised. The control is a five-state machine:
- `ST_IDLE` waits for select. It leaves for `ST_FETCH` once select is seen active.
- `ST_FETCH` raises the FIFO request. It goes to `ST_SHIFT` on the FIFO valid response, back to `ST_IDLE` if select drops, and to `ST_ABORT` on timeout.
- `ST_SHIFT` moves one bit per sample edge. It goes to `ST_FULL` on the last bit, to `ST_IDLE` if select drops (the word is discarded), and to `ST_ABORT` on timeout.
- `ST_FULL` ignores further edges and returns to `ST_IDLE` with the valid strobe when select drops.
- `ST_ABORT` ignores everything until select drops, then returns to `ST_IDLE` with no strobe.

Top module: `spi_tgt_core`

## Requirements
- R1: While reset is held, and right after it, `miso_o`, `tx_req_o`, `rx_valid_o` and `irq_timeout_o` are all 0.
- R2: MOSI is captured MSB first on the sample edge. With `cfg_cpha_i`=0 the sample edge is the leading edge; with `cfg_cpha_i`=1 it is the trailing edge. The leading edge is rising when `cfg_cpol_i`=0 and falling when `cfg_cpol_i`=1.
- R3: MISO carries the fetched word MSB first. Its first bit is present before the first serial clock edge, and it moves to the next bit after each sample edge, so the bit is stable at the master's next sample edge.
- R4: `tx_req_o` rises once per frame after select becomes active and stays high until `tx_valid_i` is seen. The word on `tx_data_i` in that cycle is the one sent.
- R5: After a complete word, releasing select (`ss_n_i`=1) gives exactly one `rx_valid_o` pulse of one cycle, with `rx_data_o` equal to the received word. `rx_data_o` holds that value afterwards.
- R6: If select is released before the word is complete, the partial word is discarded: no `rx_valid_o` pulse and no interrupt.
- R7: If no serial clock edge is detected for 64 consecutive system cycles while a frame is active and its word is incomplete, the frame is aborted. `irq_timeout_o` pulses for exactly one cycle, and no `rx_valid_o` follows when select is released.
- R8: A gap between serial clock edges shorter than the timeout does not abort the frame. The word is received correctly and no interrupt is raised.
- R9: A mode write (`cfg_wr_i`=1) while no frame is active takes effect for the next frame. A mode write during a frame does not change the current frame's sampling or output. It takes effect only after select is released.
- R10: While select is inactive and the core is idle, `miso_o` is 0.
- R11: Frames are received and sent correctly at serial clock rates up to the system clock divided by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_i | input | 1 | Select, active low (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| miso_o | output | 1 | Serial data to the master |
| cfg_wr_i | input | 1 | Mode write strobe |
| cfg_cpol_i | input | 1 | Clock polarity to write |
| cfg_cpha_i | input | 1 | Clock phase to write |
| tx_req_o | output | 1 | Request for a transmit word |
| tx_valid_i | input | 1 | Transmit word is valid |
| tx_data_i | input | WORD_W | Transmit word |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |
| irq_timeout_o | output | 1 | One-cycle timeout interrupt pulse |

## Verification
The main function is swept over all four polarity/phase modes, three serial clock half-periods (2, 3 and 5 system cycles) and several data words per mode. The slowest rate separates a wrong edge choice from a latency fault. The fastest rate shows whether MISO moves early enough. Words with mixed bit patterns separate bit order and off-by-one faults.

A stall of 62 cycles and a stall of 66 cycles bracket the timeout threshold. A frame cut short tells discard apart from a wrongly issued strobe. A phase change written in mid-frame, with the following frame run in the new mode, tells deferral apart from immediate application.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT,
        ST_FULL,
        ST_ABORT
    } tgt_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_mode_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_s,
    input  spi_mode_t mode_i,
    output logic      samp_o,
    output logic      any_o
);
    logic sclk_d;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    always_comb begin
        rise   = sclk_s & ~sclk_d;
        fall   = ~sclk_s & sclk_d;
        lead   = mode_i.cpol ? fall : rise;
        trail  = mode_i.cpol ? rise : fall;
        samp_o = mode_i.cpha ? trail : lead;
        any_o  = rise | fall;
    end
endmodule

// File: rtl/spi_tgt_cfg.sv
module spi_tgt_cfg
    import spi_tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  spi_mode_t wr_mode_i,
    input  logic      busy_i,
    output spi_mode_t mode_o
);
    spi_mode_t mode_q, pend_q;
    logic      pend_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            pend_q   <= '0;
            pend_vld <= 1'b0;
        end else if (wr_i && !busy_i) begin
            mode_q   <= wr_mode_i;
            pend_vld <= 1'b0;
        end else if (wr_i) begin
            pend_q   <= wr_mode_i;
            pend_vld <= 1'b1;
        end else if (!busy_i && pend_vld) begin
            mode_q   <= pend_q;
            pend_vld <= 1'b0;
        end
    end

    assign mode_o = mode_q;

    // R9: the working mode never moves while a frame was in progress
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable(mode_q));
endmodule

// File: rtl/spi_tgt_core.sv
module spi_tgt_core
    import spi_tgt_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              cfg_wr_i,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    output logic              tx_req_o,
    input  logic              tx_valid_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              irq_timeout_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYC - 1);

    logic        sclk_s, ss_n_s, mosi_s;
    logic        samp_edge, any_edge;
    spi_mode_t   mode, wr_mode;
    tgt_state_e  state, state_nx;

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sh, tx_sh;
    logic [TO_W-1:0]   to_cnt;
    logic              frame_run, timeout;
    logic              rx_valid_q, irq_q;
    logic [WORD_W-1:0] rx_data_q;

    spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
    spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
        .clk(clk), .rst_n(rst_n), .d_i(ss_n_i), .q_o(ss_n_s));
    spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d_i(mosi_i), .q_o(mosi_s));

    spi_tgt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .mode_i(mode),
        .samp_o(samp_edge), .any_o(any_edge));

    assign wr_mode = '{cpol: cfg_cpol_i, cpha: cfg_cpha_i};

    spi_tgt_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .wr_mode_i(wr_mode),
        .busy_i(state != ST_IDLE), .mode_o(mode));

    // stall detection: frame open and word incomplete
    assign frame_run = (state == ST_FETCH) || (state == ST_SHIFT);
    assign timeout   = frame_run && !any_edge && (to_cnt == TO_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!ss_n_s) state_nx = ST_FETCH;
            ST_FETCH: begin
                if (ss_n_s)          state_nx = ST_IDLE;
                else if (timeout)    state_nx = ST_ABORT;
                else if (tx_valid_i) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (ss_n_s)       state_nx = ST_IDLE;
                else if (timeout) state_nx = ST_ABORT;
                else if (samp_edge && bit_cnt == LAST_BIT) state_nx = ST_FULL;
            end
            ST_FULL:  if (ss_n_s) state_nx = ST_IDLE;
            ST_ABORT: if (ss_n_s) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_cnt  <= '0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            if (frame_run && !any_edge) to_cnt <= to_cnt + 1'b1;
            else                        to_cnt <= '0;

            if (state == ST_FETCH && state_nx == ST_SHIFT) begin
                tx_sh   <= tx_data_i;
                rx_sh   <= '0;
                bit_cnt <= '0;
            end else if (state == ST_SHIFT && samp_edge && !ss_n_s) begin
                rx_sh   <= {rx_sh[WORD_W-2:0], mosi_s};
                tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
            irq_q      <= 1'b0;
        end else begin
            rx_valid_q <= (state == ST_FULL) && (state_nx == ST_IDLE);
            if ((state == ST_FULL) && (state_nx == ST_IDLE)) rx_data_q <= rx_sh;
            irq_q      <= (state != ST_ABORT) && (state_nx == ST_ABORT);
        end
    end

    assign tx_req_o      = (state == ST_FETCH);
    assign miso_o        = ((state == ST_SHIFT) || (state == ST_FULL)) & tx_sh[WORD_W-1];
    assign rx_valid_o    = rx_valid_q;
    assign rx_data_o     = rx_data_q;
    assign irq_timeout_o = irq_q;

    // R5: a received-word strobe only follows a completed word
    a_r5_valid_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(state) == ST_FULL);

    // R7: the timeout interrupt lasts a single cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout_o |=> !irq_timeout_o);

    // R7: the interrupt coincides with the aborted state
    a_r7_irq_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout_o |-> state == ST_ABORT);

    // R2: the bit counter never passes the word length
    a_r2_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_W));

    // R6: a discarded or aborted frame never yields a strobe on leaving
    a_r6_no_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT || state == ST_ABORT) && ss_n_s |=> !rx_valid_o);
endmodule

// File: tb/test_spi_tgt_core.sv
`timescale 1ns/1ps
module test_spi_tgt_core;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, sclk, ss_n, mosi, miso;
    logic cfg_wr, cfg_cpol, cfg_cpha;
    logic tx_req, tx_valid;
    logic [W-1:0] tx_data, rx_data;
    logic rx_valid, irq;

    spi_tgt_core #(.WORD_W(W), .TIMEOUT_CYC(64), .SYNC_STAGES(2)) i_spi_tgt_core (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ss_n_i(ss_n), .mosi_i(mosi),
        .miso_o(miso), .cfg_wr_i(cfg_wr), .cfg_cpol_i(cfg_cpol), .cfg_cpha_i(cfg_cpha),
        .tx_req_o(tx_req), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .irq_timeout_o(irq));

    int n_cmp = 0, n_bad = 0;
    int n_rxv = 0, n_irq = 0, n_req = 0;
    logic req_d = 1'b0;
    logic [W-1:0] last_rx = '0;

    // FIFO model and output monitors, all at the falling edge
    always @(negedge clk) begin
        tx_valid <= tx_req;
        if (rx_valid) begin n_rxv++; last_rx = rx_data; end
        if (irq) n_irq++;
        if (tx_req && !req_d) n_req++;
        req_d = tx_req;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input bit pol, input bit pha);
        cfg_cpol = pol; cfg_cpha = pha; cfg_wr = 1'b1;
        wait_clk(1);
        cfg_wr = 1'b0;
    endtask

    // master model: nb bits, optional stall after bit sb, optional mode write after bit 2
    task automatic frame(input bit pol, input bit pha, input int h, input logic [W-1:0] mo,
                         input int nb, input int sb, input int stall,
                         input bit midw, input bit mpol, input bit mpha,
                         output logic [W-1:0] mi);
        mi = '0;
        sclk = pol;
        wait_clk(4);
        ss_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nb; i++) begin
            if (!pha) begin
                mosi = mo[W-1-i];
                wait_clk(h);
                mi[W-1-i] = miso;
                sclk = ~sclk;
                wait_clk(h);
                sclk = ~sclk;
            end else begin
                sclk = ~sclk;
                mosi = mo[W-1-i];
                wait_clk(h);
                mi[W-1-i] = miso;
                sclk = ~sclk;
                wait_clk(h);
            end
            if (midw && i == 2) set_mode(mpol, mpha);
            if (i == sb) wait_clk(stall);
        end
        wait_clk(4);
        ss_n = 1'b1;
        wait_clk(8);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] mo, tx, mi;
        int v0, i0, r0;
        rst_n = 1'b0; sclk = 1'b0; ss_n = 1'b1; mosi = 1'b0;
        cfg_wr = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; tx_data = '0;
        wait_clk(5);
        // R1: reset state
        check("R1 outputs in reset", {28'd0, miso, tx_req, rx_valid, irq}, 32'd0);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 outputs after reset", {28'd0, miso, tx_req, rx_valid, irq}, 32'd0);

        // R2 R3 R5 R10 R11: sweep of modes, rates and words
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            wait_clk(2);
            for (int hi = 0; hi < 3; hi++) begin
                for (int d = 0; d < 4; d++) begin
                    int h;
                    h  = (hi == 0) ? 2 : (hi == 1) ? 3 : 5;
                    mo = W'(37 * d + 11 * m + 5 * hi + 1);
                    tx = W'(mo * 3 + 90);
                    tx_data = tx;
                    v0 = n_rxv; r0 = n_req;
                    frame(m[1], m[0], h, mo, W, -1, 0, 1'b0, 1'b0, 1'b0, mi);
                    check((hi == 0) ? "R2 R11 rx word" : "R2 rx word", 32'(last_rx), 32'(mo));
                    check((hi == 0) ? "R3 R11 miso word" : "R3 miso word", 32'(mi), 32'(tx));
                    check("R5 one strobe per frame", 32'(n_rxv - v0), 32'd1);
                    check("R4 one request per frame", 32'(n_req - r0), 32'd1);
                    check("R10 idle miso and no request", {30'd0, miso, tx_req}, 32'd0);
                end
            end
        end
        check("R5 rx_data holds", 32'(rx_data), 32'(last_rx));

        // R6: frame cut short is discarded
        set_mode(1'b0, 1'b0);
        wait_clk(2);
        v0 = n_rxv; i0 = n_irq;
        tx_data = 8'hC3;
        frame(1'b0, 1'b0, 2, 8'h96, 5, -1, 0, 1'b0, 1'b0, 1'b0, mi);
        check("R6 short frame no strobe", 32'(n_rxv - v0), 32'd0);
        check("R6 short frame no irq", 32'(n_irq - i0), 32'd0);
        check("R6 rx_data unchanged", 32'(rx_data), 32'(last_rx));

        // R8: edge gap of 62 cycles does not abort
        v0 = n_rxv; i0 = n_irq;
        tx_data = 8'h3C;
        frame(1'b0, 1'b0, 2, 8'hB7, W, 3, 60, 1'b0, 1'b0, 1'b0, mi);
        check("R8 no irq below limit", 32'(n_irq - i0), 32'd0);
        check("R8 word after stall", 32'(last_rx), 32'hB7);
        check("R8 strobe after stall", 32'(n_rxv - v0), 32'd1);
        check("R8 miso after stall", 32'(mi), 32'h3C);

        // R7: edge gap of 66 cycles aborts
        v0 = n_rxv; i0 = n_irq;
        frame(1'b0, 1'b0, 2, 8'h5D, W, 3, 64, 1'b0, 1'b0, 1'b0, mi);
        check("R7 one irq pulse", 32'(n_irq - i0), 32'd1);
        check("R7 no strobe after abort", 32'(n_rxv - v0), 32'd0);
        check("R7 rx_data unchanged", 32'(rx_data), 32'hB7);

        // R9: mode write in mid-frame is deferred
        tx_data = 8'hA6;
        frame(1'b0, 1'b0, 3, 8'h4E, W, -1, 0, 1'b1, 1'b0, 1'b1, mi);
        check("R9 old mode rx word", 32'(last_rx), 32'h4E);
        check("R9 old mode miso word", 32'(mi), 32'hA6);
        tx_data = 8'h71;
        frame(1'b0, 1'b1, 3, 8'hD2, W, -1, 0, 1'b0, 1'b0, 1'b0, mi);
        check("R9 new mode rx word", 32'(last_rx), 32'hD2);
        check("R9 new mode miso word", 32'(mi), 32'h71);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule